// File: doc/BRIEF.md
# Split-Rate Read-Return Receiver

This block sits on the requesting side of a graphics-port style bus. It collects the data the target returns for earlier read requests and assembles it into complete per-transaction results. In single-rate mode it takes one 32-bit word per clock. In double-rate mode it takes two words per clock: the first-half word and a second word that the source strobe qualifies. The target-ready input and a 3-bit status code decide, clock by clock, whether the bus holds usable read-return data.

The request side feeds a small length queue. It holds one entry per outstanding read and gives the expected length (8, 16 or 32 bytes). The receiver frames each transaction against the head entry and tags it high or low priority from the status code seen on its first beat. It then hands the assembled result to a valid/ready output through a short buffer. If a transaction completes while that buffer is full, the result is dropped and a sticky overflow flag is raised.

Top module: `agp_rdret_rx`

## Requirements
- R1: After reset, out_valid_o and overflow_o are 0 and len_ready_o is 1.
- R2: A clock captures data only when trdy_ni is 0 and status_i is 3'b000 or 3'b001. Any other clock is a wait state and changes nothing.
- R3: With mode_2x_i = 0, each capturing clock takes one word from bus_lo_i. strobe_i and bus_hi_i have no effect.
- R4: With mode_2x_i = 1, a clock captures only if strobe_i is 1. It then takes two words, bus_lo_i before bus_hi_i. A clock with strobe_i = 0 is a wait state.
- R5: len_code_i gives the transaction length: 0 means 8 bytes, 1 means 16 bytes, and 2 or 3 mean 32 bytes. An entry is accepted when len_valid_i and len_ready_o are both 1, and len_ready_o is 0 once LEN_DEPTH entries are queued. The head entry is removed when the last word of its transaction is captured. Capturing clocks are ignored while the queue is empty.
- R6: Word k of a transaction appears at out_data_o[32k+31:32k], in capture order. Bits above the transaction length are 0, and out_bytes_o gives the length in bytes.
- R7: out_hi_prio_o is 1 when the status on the first beat of the transaction was 3'b001, and 0 when it was 3'b000. Status changes on later beats do not alter it.
- R8: In mode_2x_i = 1, 8-byte transactions on consecutive clocks each produce a separate result, including runs with the same priority.
- R9: A result becomes valid the clock after its last beat. It stays stable while out_ready_i is 0. Up to OUT_DEPTH results are buffered, and they are delivered in completion order.
- R10: If a transaction completes while the buffer holds OUT_DEPTH results and none leaves in that clock, the result is discarded and overflow_o goes to 1. It stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_2x_i | input | 1 | 1 selects double-rate capture |
| strobe_i | input | 1 | Second-word strobe qualifier (double rate) |
| trdy_ni | input | 1 | Target ready, active low |
| status_i | input | 3 | Bus status code |
| bus_lo_i | input | 32 | First-half data word |
| bus_hi_i | input | 32 | Strobed second-half data word |
| len_valid_i | input | 1 | Length entry offered |
| len_code_i | input | 2 | Length code of the offered entry |
| len_ready_o | output | 1 | Length queue can accept |
| out_valid_o | output | 1 | Result available |
| out_ready_i | input | 1 | Consumer takes the result |
| out_data_o | output | 256 | Assembled transaction data |
| out_bytes_o | output | 6 | Transaction length in bytes |
| out_hi_prio_o | output | 1 | Result is high priority |
| overflow_o | output | 1 | Sticky dropped-result flag |

## Verification
The assertions check on every clock that a stalled result holds still, that the overflow flag is sticky and rises only when the buffer is full and stalled, that reported lengths are legal, and that a wait-state clock can never produce a new result. Whether the words land in the right slots, whether the priority comes from the first beat, and how the length queue frames the beats can only be shown by the bench. It sweeps both rates, every length code and both priorities with wait states mixed in, and then runs back-to-back, empty-queue and overflow scenarios.

// File: rtl/agp_rx_pkg.sv
package agp_rx_pkg;
  localparam logic [2:0] STATUS_RD_LO = 3'b000;
  localparam logic [2:0] STATUS_RD_HI = 3'b001;

  // length code -> words of 4 bytes, capped at max_words
  function automatic int unsigned code_to_words(input logic [1:0] code, input int unsigned max_words);
    int unsigned w;
    w = 2 << code;
    return (w > max_words) ? max_words : w;
  endfunction
endpackage

// File: rtl/agp_rx_fifo.sv
module agp_rx_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign rdata_o = mem_q[rd_ptr_q];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end
endmodule

// File: rtl/agp_rx_assembler.sv
module agp_rx_assembler #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned MAX_WORDS = 8,
  localparam int unsigned CNT_W    = $clog2(MAX_WORDS + 1),
  localparam int unsigned BUS_W    = WORD_W * MAX_WORDS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_i,
  input  logic              dual_i,
  input  logic [WORD_W-1:0] lo_i,
  input  logic [WORD_W-1:0] hi_i,
  input  logic              hi_prio_i,
  input  logic [CNT_W-1:0]  tgt_words_i,
  output logic              done_o,
  output logic [BUS_W-1:0]  data_o,
  output logic              hi_prio_o
);
  logic [WORD_W-1:0] data_q [MAX_WORDS];
  logic [WORD_W-1:0] slot_w [MAX_WORDS];
  logic [CNT_W-1:0]  cnt_q, cnt_p1;
  logic [CNT_W:0]    cnt_nxt;
  logic              prio_q, prio_cur, first;

  assign first    = (cnt_q == '0);
  assign prio_cur = first ? hi_prio_i : prio_q;
  assign cnt_p1   = cnt_q + 1'b1;
  assign cnt_nxt  = {1'b0, cnt_q} + (dual_i ? (CNT_W+1)'(2) : (CNT_W+1)'(1));
  assign done_o   = beat_i && (cnt_nxt >= {1'b0, tgt_words_i});
  assign hi_prio_o = prio_cur;

  for (genvar i = 0; i < MAX_WORDS; i++) begin : g_slot
    assign slot_w[i] = (beat_i && cnt_q == CNT_W'(i))            ? lo_i :
                       (beat_i && dual_i && cnt_p1 == CNT_W'(i)) ? hi_i :
                       data_q[i];
    assign data_o[i*WORD_W +: WORD_W] = slot_w[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prio_q <= 1'b0;
      for (int i = 0; i < MAX_WORDS; i++) data_q[i] <= '0;
    end else if (done_o) begin
      cnt_q  <= '0;
      prio_q <= 1'b0;
      for (int i = 0; i < MAX_WORDS; i++) data_q[i] <= '0;
    end else if (beat_i) begin
      cnt_q  <= cnt_nxt[CNT_W-1:0];
      prio_q <= prio_cur;
      for (int i = 0; i < MAX_WORDS; i++) data_q[i] <= slot_w[i];
    end
  end
endmodule

// File: rtl/agp_rdret_rx.sv
module agp_rdret_rx #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned MAX_WORDS = 8,
  parameter int unsigned LEN_DEPTH = 4,
  parameter int unsigned OUT_DEPTH = 2,
  localparam int unsigned BUS_W    = WORD_W * MAX_WORDS,
  localparam int unsigned BYTES_W  = $clog2(MAX_WORDS * WORD_W / 8 + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_2x_i,
  input  logic               strobe_i,
  input  logic               trdy_ni,
  input  logic [2:0]         status_i,
  input  logic [WORD_W-1:0]  bus_lo_i,
  input  logic [WORD_W-1:0]  bus_hi_i,
  input  logic               len_valid_i,
  input  logic [1:0]         len_code_i,
  output logic               len_ready_o,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [BUS_W-1:0]   out_data_o,
  output logic [BYTES_W-1:0] out_bytes_o,
  output logic               out_hi_prio_o,
  output logic               overflow_o
);
  import agp_rx_pkg::*;
  localparam int unsigned CNT_W = $clog2(MAX_WORDS + 1);
  localparam int unsigned OUT_W = BUS_W + BYTES_W + 1;

  logic             len_full, len_empty, len_push, status_ok, beat, done, asm_prio;
  logic [1:0]       len_head;
  logic [CNT_W-1:0] tgt_words;
  logic [BUS_W-1:0] asm_data;
  logic [BYTES_W-1:0] asm_bytes;
  logic             out_full, out_empty, out_pop, drop;
  logic [OUT_W-1:0] out_wdata, out_rdata;
  logic             ovf_q;

  assign len_ready_o = !len_full;
  assign len_push    = len_valid_i && !len_full;

  agp_rx_fifo #(.WIDTH(2), .DEPTH(LEN_DEPTH)) u_len_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (len_push),
    .wdata_i (len_code_i),
    .pop_i   (done),
    .rdata_o (len_head),
    .full_o  (len_full),
    .empty_o (len_empty)
  );

  assign tgt_words = CNT_W'(code_to_words(len_head, MAX_WORDS));
  assign asm_bytes = BYTES_W'(tgt_words) * BYTES_W'(WORD_W / 8);
  assign status_ok = (status_i == STATUS_RD_LO) || (status_i == STATUS_RD_HI);
  assign beat      = !trdy_ni && status_ok && (!mode_2x_i || strobe_i) && !len_empty;

  agp_rx_assembler #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS)) u_asm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .beat_i      (beat),
    .dual_i      (mode_2x_i),
    .lo_i        (bus_lo_i),
    .hi_i        (bus_hi_i),
    .hi_prio_i   (status_i == STATUS_RD_HI),
    .tgt_words_i (tgt_words),
    .done_o      (done),
    .data_o      (asm_data),
    .hi_prio_o   (asm_prio)
  );

  assign out_wdata = {asm_data, asm_bytes, asm_prio};
  assign out_pop   = out_valid_o && out_ready_i;
  // full buffer implies valid, so a stalled consumer means no slot frees
  assign drop      = done && out_full && !out_ready_i;

  agp_rx_fifo #(.WIDTH(OUT_W), .DEPTH(OUT_DEPTH)) u_out_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (done),
    .wdata_i (out_wdata),
    .pop_i   (out_pop),
    .rdata_o (out_rdata),
    .full_o  (out_full),
    .empty_o (out_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ovf_q <= 1'b0;
    else if (drop) ovf_q <= 1'b1;
  end

  assign out_valid_o   = !out_empty;
  assign out_data_o    = out_rdata[OUT_W-1 -: BUS_W];
  assign out_bytes_o   = out_rdata[BYTES_W:1];
  assign out_hi_prio_o = out_rdata[0];
  assign overflow_o    = ovf_q;
endmodule

module agp_rdret_rx_chk #(
  parameter int unsigned BUS_W   = 256,
  parameter int unsigned BYTES_W = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mode_2x_i,
  input logic               strobe_i,
  input logic               trdy_ni,
  input logic [2:0]         status_i,
  input logic               out_valid_o,
  input logic               out_ready_i,
  input logic [BUS_W-1:0]   out_data_o,
  input logic [BYTES_W-1:0] out_bytes_o,
  input logic               out_hi_prio_o,
  input logic               overflow_o,
  input logic               out_full_i
);
  assert_wait_trdy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trdy_ni |=> !$rose(out_valid_o));
  assert_wait_status_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_i inside {3'b000, 3'b001}) |=> !$rose(out_valid_o));
  assert_no_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_2x_i && !strobe_i) |=> !$rose(out_valid_o));
  assert_legal_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ($countones(out_bytes_o) == 1 && out_bytes_o >= BYTES_W'(8)));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)
      && $stable(out_bytes_o) && $stable(out_hi_prio_o)));
  assert_sticky_ovf_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  assert_ovf_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(out_full_i && !out_ready_i));
endmodule

bind agp_rdret_rx agp_rdret_rx_chk #(.BUS_W(BUS_W), .BYTES_W(BYTES_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_2x_i     (mode_2x_i),
  .strobe_i      (strobe_i),
  .trdy_ni       (trdy_ni),
  .status_i      (status_i),
  .out_valid_o   (out_valid_o),
  .out_ready_i   (out_ready_i),
  .out_data_o    (out_data_o),
  .out_bytes_o   (out_bytes_o),
  .out_hi_prio_o (out_hi_prio_o),
  .overflow_o    (overflow_o),
  .out_full_i    (out_full)
);

// File: tb/agp_rdret_rx_test.sv
`timescale 1ns/1ps
module agp_rdret_rx_test;
  localparam int BUS_W = 256;
  localparam int BYTES_W = 6;
  localparam int LEN_DEPTH = 4;
  localparam int EXP_W = BUS_W + BYTES_W + 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mode_2x_i = 1'b0, strobe_i = 1'b0, trdy_ni = 1'b1;
  logic [2:0] status_i = 3'b111;
  logic [31:0] bus_lo_i = '0, bus_hi_i = '0;
  logic len_valid_i = 1'b0;
  logic [1:0] len_code_i = '0;
  logic len_ready_o, out_valid_o, out_ready_i = 1'b1, out_hi_prio_o, overflow_o;
  logic [BUS_W-1:0] out_data_o;
  logic [BYTES_W-1:0] out_bytes_o;

  int checks = 0, errors = 0, cyc = 0, rx_cnt = 0, txn_id = 0;
  logic [EXP_W-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  agp_rdret_rx uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_2x_i(mode_2x_i), .strobe_i(strobe_i),
    .trdy_ni(trdy_ni), .status_i(status_i), .bus_lo_i(bus_lo_i), .bus_hi_i(bus_hi_i),
    .len_valid_i(len_valid_i), .len_code_i(len_code_i), .len_ready_o(len_ready_o),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
    .out_bytes_o(out_bytes_o), .out_hi_prio_o(out_hi_prio_o), .overflow_o(overflow_o)
  );

  task automatic chk(input bit ok, input string req, input logic [BUS_W-1:0] act,
                     input logic [BUS_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // result monitor: head is taken at the next edge
  always @(negedge clk) begin
    if (rst_ni && out_valid_o && out_ready_i) begin
      rx_cnt++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected result", BUS_W'(out_bytes_o), '0);
      end else begin
        logic [EXP_W-1:0] e;
        e = exp_q.pop_front();
        chk(out_data_o == e[EXP_W-1 -: BUS_W], "R6 R3 R4 data", out_data_o, e[EXP_W-1 -: BUS_W]);
        chk(out_bytes_o == e[BYTES_W:1], "R5 length", BUS_W'(out_bytes_o), BUS_W'(e[BYTES_W:1]));
        chk(out_hi_prio_o == e[0], "R7 priority", BUS_W'(out_hi_prio_o), BUS_W'(e[0]));
      end
    end
  end

  function automatic logic [31:0] word_of(input int t, input int k);
    return {8'hA5, 8'(t), 16'(k)};
  endfunction

  task automatic drive(input logic tr, input logic [2:0] st, input logic sb,
                       input logic [31:0] lo, input logic [31:0] hi,
                       input logic lv, input logic [1:0] lc);
    @(posedge clk); #1;
    trdy_ni = tr; status_i = st; strobe_i = sb; bus_lo_i = lo; bus_hi_i = hi;
    len_valid_i = lv; len_code_i = lc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 3'b111, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 2'd0);
  endtask

  task automatic push_len(input logic [1:0] code);
    drive(1'b1, 3'b111, 1'b0, '0, '0, 1'b1, code);
  endtask

  // beats of one transaction; optional wait states and mid-transaction status flip
  task automatic send_txn(input bit m2x, input logic [1:0] code, input bit prio,
                          input bit waits, input bit flip, input bit keep);
    int words, per;
    logic [BUS_W-1:0] d;
    logic [2:0] st;
    words = (code == 2'd0) ? 2 : (code == 2'd1) ? 4 : 8;
    per = m2x ? 2 : 1;
    d = '0;
    mode_2x_i = m2x;
    for (int b = 0; b < words / per; b++) begin
      int k;
      k = b * per;
      if (waits) begin
        case (b % 3)
          0: drive(1'b1, 3'b001, 1'b1, 32'hDEAD_0000, 32'hDEAD_0001, 1'b0, 2'd0);
          1: drive(1'b0, 3'b011, 1'b1, 32'hDEAD_0002, 32'hDEAD_0003, 1'b0, 2'd0);
          default:
            if (m2x) drive(1'b0, prio ? 3'b001 : 3'b000, 1'b0, 32'hDEAD_0004, 32'hDEAD_0005, 1'b0, 2'd0);
            else     drive(1'b1, 3'b000, 1'b1, 32'hDEAD_0006, 32'hDEAD_0007, 1'b0, 2'd0);
        endcase
      end
      st = (flip && b > 0) ? (prio ? 3'b000 : 3'b001) : (prio ? 3'b001 : 3'b000);
      d[k*32 +: 32] = word_of(txn_id, k);
      if (m2x) d[(k+1)*32 +: 32] = word_of(txn_id, k + 1);
      drive(1'b0, st, m2x ? 1'b1 : 1'(b & 1), word_of(txn_id, k),
            m2x ? word_of(txn_id, k + 1) : 32'hBAD0_0000, 1'b0, 2'd0);
    end
    if (keep) exp_q.push_back({d, BYTES_W'(words * 4), prio});
    txn_id++;
  endtask

  initial begin
    int base;
    logic [BUS_W-1:0] held;
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid_o == 1'b0, "R1 valid after reset", BUS_W'(out_valid_o), '0);
    chk(overflow_o == 1'b0, "R1 overflow after reset", BUS_W'(overflow_o), '0);
    chk(len_ready_o == 1'b1, "R1 len_ready after reset", BUS_W'(len_ready_o), 1);
    rst_ni = 1'b1;
    idle(2);

    // sweep: both rates, all codes, both priorities, waits and priority flips (R2 R3 R4 R5 R6 R7)
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 4; c++)
        for (int p = 0; p < 2; p++) begin
          push_len(2'(c));
          send_txn(1'(m), 2'(c), 1'(p), 1'((c + p) & 1), 1'(p ^ m), 1'b1);
          idle(2);
        end
    idle(3);
    chk(exp_q.size() == 0, "R9 sweep results delivered", BUS_W'(exp_q.size()), '0);

    // R5: queue fills, extra entry refused, empty queue ignores beats
    for (int i = 0; i < LEN_DEPTH; i++) push_len(2'd0);
    idle(1);
    chk(len_ready_o == 1'b0, "R5 len_ready low when full", BUS_W'(len_ready_o), '0);
    push_len(2'd1);
    idle(1);
    for (int i = 0; i < LEN_DEPTH; i++) send_txn(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(2);
    chk(len_ready_o == 1'b1, "R5 len_ready after drain", BUS_W'(len_ready_o), 1);
    base = rx_cnt;
    send_txn(1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(4);
    chk(rx_cnt == base && out_valid_o == 1'b0, "R5 beats ignored with empty queue",
        BUS_W'(rx_cnt - base), '0);

    // R8: back-to-back 8-byte transactions, same priority then alternating
    for (int i = 0; i < 4; i++) push_len(2'd0);
    base = rx_cnt;
    for (int i = 0; i < 4; i++) send_txn(1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1);
    idle(3);
    chk(rx_cnt - base == 4, "R8 same-priority back-to-back count", BUS_W'(rx_cnt - base), 4);
    for (int i = 0; i < 4; i++) push_len(2'd0);
    base = rx_cnt;
    for (int i = 0; i < 4; i++) send_txn(1'b1, 2'd0, 1'(i & 1), 1'b0, 1'b0, 1'b1);
    idle(3);
    chk(rx_cnt - base == 4, "R8 alternating back-to-back count", BUS_W'(rx_cnt - base), 4);

    // R9 R10: stall the output, overflow on the third result
    drive(1'b1, 3'b111, 1'b0, '0, '0, 1'b0, 2'd0);
    out_ready_i = 1'b0;
    for (int i = 0; i < 3; i++) push_len(2'd0);
    send_txn(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    send_txn(1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1);
    idle(1);
    chk(overflow_o == 1'b0, "R10 no overflow while space", BUS_W'(overflow_o), '0);
    send_txn(1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(1);
    chk(overflow_o == 1'b1, "R10 overflow raised", BUS_W'(overflow_o), 1);
    held = out_data_o;
    idle(3);
    chk(out_valid_o == 1'b1 && out_data_o == held, "R9 result held while stalled", out_data_o, held);
    base = rx_cnt;
    drive(1'b1, 3'b111, 1'b0, '0, '0, 1'b0, 2'd0);
    out_ready_i = 1'b1;
    idle(4);
    chk(rx_cnt - base == 2, "R10 dropped result not delivered", BUS_W'(rx_cnt - base), 2);
    chk(overflow_o == 1'b1, "R10 overflow sticky", BUS_W'(overflow_o), 1);
    chk(exp_q.size() == 0, "R9 all results delivered", BUS_W'(exp_q.size()), '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule